// File: doc/BRIEF.md
# Multi-class interrupt pending store

This block keeps the set of pending interrupts for one processor thread. Interrupts fall into seven classes, each with its own 64-bit pending vector. A summary word carries one bit per class, so a downstream priority selector can see which classes have work without scanning every vector. Both the summary word and the full set of vectors are outputs that go straight to that selector.

Sources raise interrupts through a post port, which names a class and a bit index. Handlers retire them through a clear port of the same shape. A clear-all input wipes all state at once. A combinational read port returns the vector of any class by number. A request that names a class outside the valid range is dropped, and a one-cycle error flag reports it. The summary bit of a class is not stored: it is computed from that class's vector, so it falls only when the last pending bit of the class is removed.

Top module: `irq_pending_store`

## Requirements
- R1: After a synchronous reset, all class vectors, the summary word and the error flag read zero.
- R2: A post with a valid class sets the addressed bit of that class vector and sets the class's summary bit. Both are visible on the outputs in the cycle after the clock edge that takes the request.
- R3: A clear with a valid class resets the addressed bit. The class's summary bit stays set while any other bit of that vector is still set, and it drops in the same cycle that the vector becomes all zero.
- R4: Clear-all zeroes every vector and the summary word at the next edge. It wins over a post or clear in the same cycle.
- R5: The read port returns, without a clock delay, the vector of the class on rd_class. A class number of 7 returns zero.
- R6: When a post and a clear reach the same class in one cycle, the clear is applied first and the post second. If both name the same bit, that bit ends up set.
- R7: A post or clear with class number 7 changes no state. For each cycle that carries such a request, the error flag is high in the following cycle only.
- R8: The class codes are 0 trap-level-zero, 1 hypervisor tick match, 2 interrupt vector, 3 CPU mondo, 4 device mondo, 5 soft interrupt, 6 resumable error. Class c occupies bits [c*64+63 : c*64] of all_vecs and bit c of summary.
- R9: Posting a bit that is already set, or clearing a bit that is already clear, leaves all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_all | input | 1 | Wipe all pending state at the next edge |
| post_valid | input | 1 | Post request strobe |
| post_class | input | 3 | Class of the post |
| post_index | input | 6 | Bit index of the post |
| clear_valid | input | 1 | Clear request strobe |
| clear_class | input | 3 | Class of the clear |
| clear_index | input | 6 | Bit index of the clear |
| rd_class | input | 3 | Class selected on the read port |
| rd_vec | output | 64 | Pending vector of rd_class |
| summary | output | 7 | One non-empty flag per class |
| all_vecs | output | 448 | All class vectors, class c at c*64 |
| bad_class | output | 1 | Out-of-range class seen in the previous cycle |

## Verification
A wrong stored bit shows on all_vecs and rd_vec one cycle after the request that caused it, and the summary word shows the same fault if the bit was the last or first one of its class. The scoreboard compares the whole 448-bit image, the summary and the error flag after every request. A misrouted bit, a summary that drops too early, a lost post under a same-cycle clear, or a rejected class that still writes state is therefore caught in the cycle right after the request. The read-port checks catch a bad selection at once, because that path has no register.

// File: rtl/irq_store_pkg.sv
package irq_store_pkg;

    localparam int IRQ_NUM_CLASSES = 7;
    localparam int IRQ_VEC_W       = 64;

    // Class codes; the order is the bit position in the summary word.
    typedef enum logic [2:0] {
        CLS_TL_ZERO   = 3'd0,
        CLS_HTICK     = 3'd1,
        CLS_VECTOR    = 3'd2,
        CLS_CPU_MONDO = 3'd3,
        CLS_DEV_MONDO = 3'd4,
        CLS_SOFT      = 3'd5,
        CLS_RES_ERR   = 3'd6
    } irq_class_e;

    // Next value of one class vector: clear first, then set.
    function automatic logic [IRQ_VEC_W-1:0] vec_update(
        input logic [IRQ_VEC_W-1:0] cur,
        input logic                 do_clr,
        input logic [IRQ_VEC_W-1:0] clr_mask,
        input logic                 do_set,
        input logic [IRQ_VEC_W-1:0] set_mask
    );
        logic [IRQ_VEC_W-1:0] v;
        v = cur;
        if (do_clr) v = v & ~clr_mask;
        if (do_set) v = v | set_mask;
        return v;
    endfunction

endpackage

// File: rtl/irq_req_decode.sv
module irq_req_decode #(
    parameter int NUM_CLASSES = irq_store_pkg::IRQ_NUM_CLASSES,
    parameter int VEC_W       = irq_store_pkg::IRQ_VEC_W,
    localparam int CLS_W      = $clog2(NUM_CLASSES),
    localparam int IDX_W      = $clog2(VEC_W)
) (
    input  logic                   req_valid,
    input  logic [CLS_W-1:0]       req_class,
    input  logic [IDX_W-1:0]       req_index,
    output logic [NUM_CLASSES-1:0] class_sel,
    output logic [VEC_W-1:0]       bit_mask,
    output logic                   bad_req
);
    logic class_ok;

    always_comb begin
        class_ok  = req_class < CLS_W'(NUM_CLASSES);
        bad_req   = req_valid && !class_ok;
        class_sel = '0;
        bit_mask  = '0;
        if (req_valid && class_ok) begin
            class_sel = NUM_CLASSES'(1) << req_class;
            bit_mask  = VEC_W'(1) << req_index;
        end
    end
endmodule

// File: rtl/irq_class_vec.sv
module irq_class_vec #(
    parameter int VEC_W = irq_store_pkg::IRQ_VEC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_all,
    input  logic             set_en,
    input  logic [VEC_W-1:0] set_mask,
    input  logic             clr_en,
    input  logic [VEC_W-1:0] clr_mask,
    output logic [VEC_W-1:0] vec,
    output logic             pending
);
    import irq_store_pkg::*;

    logic [VEC_W-1:0] vec_n;

    always_comb begin
        vec_n = vec_update(vec, clr_en, clr_mask, set_en, set_mask);
    end

    always_ff @(posedge clk) begin
        if (rst || clr_all) vec <= '0;
        else                vec <= vec_n;
    end

    // Summary flag follows the contents; never stored on its own.
    assign pending = |vec;
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux #(
    parameter int NUM_CLASSES = irq_store_pkg::IRQ_NUM_CLASSES,
    parameter int VEC_W       = irq_store_pkg::IRQ_VEC_W,
    localparam int CLS_W      = $clog2(NUM_CLASSES)
) (
    input  logic [NUM_CLASSES*VEC_W-1:0] vecs_flat,
    input  logic [CLS_W-1:0]             sel,
    output logic [VEC_W-1:0]             out_vec
);
    always_comb begin
        out_vec = '0;
        for (int c = 0; c < NUM_CLASSES; c++) begin
            if (sel == CLS_W'(c)) out_vec = vecs_flat[c*VEC_W +: VEC_W];
        end
    end
endmodule

// File: rtl/irq_pending_store.sv
module irq_pending_store #(
    parameter int NUM_CLASSES = irq_store_pkg::IRQ_NUM_CLASSES,
    parameter int VEC_W       = irq_store_pkg::IRQ_VEC_W,
    localparam int CLS_W      = $clog2(NUM_CLASSES),
    localparam int IDX_W      = $clog2(VEC_W)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr_all,
    input  logic                         post_valid,
    input  logic [CLS_W-1:0]             post_class,
    input  logic [IDX_W-1:0]             post_index,
    input  logic                         clear_valid,
    input  logic [CLS_W-1:0]             clear_class,
    input  logic [IDX_W-1:0]             clear_index,
    input  logic [CLS_W-1:0]             rd_class,
    output logic [VEC_W-1:0]             rd_vec,
    output logic [NUM_CLASSES-1:0]       summary,
    output logic [NUM_CLASSES*VEC_W-1:0] all_vecs,
    output logic                         bad_class
);
    logic [NUM_CLASSES-1:0] post_sel, clear_sel;
    logic [VEC_W-1:0]       post_mask, clear_mask;
    logic                   post_bad, clear_bad;

    irq_req_decode #(.NUM_CLASSES(NUM_CLASSES), .VEC_W(VEC_W)) u_post_dec (
        .req_valid (post_valid),
        .req_class (post_class),
        .req_index (post_index),
        .class_sel (post_sel),
        .bit_mask  (post_mask),
        .bad_req   (post_bad)
    );

    irq_req_decode #(.NUM_CLASSES(NUM_CLASSES), .VEC_W(VEC_W)) u_clear_dec (
        .req_valid (clear_valid),
        .req_class (clear_class),
        .req_index (clear_index),
        .class_sel (clear_sel),
        .bit_mask  (clear_mask),
        .bad_req   (clear_bad)
    );

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_class
        irq_class_vec #(.VEC_W(VEC_W)) u_vec (
            .clk      (clk),
            .rst      (rst),
            .clr_all  (clr_all),
            .set_en   (post_sel[c]),
            .set_mask (post_mask),
            .clr_en   (clear_sel[c]),
            .clr_mask (clear_mask),
            .vec      (all_vecs[c*VEC_W +: VEC_W]),
            .pending  (summary[c])
        );
    end

    irq_read_mux #(.NUM_CLASSES(NUM_CLASSES), .VEC_W(VEC_W)) u_rd_mux (
        .vecs_flat (all_vecs),
        .sel       (rd_class),
        .out_vec   (rd_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) bad_class <= 1'b0;
        else     bad_class <= post_bad || clear_bad;
    end
endmodule

// File: rtl/irq_pending_store_chk.sv
module irq_pending_store_chk #(
    parameter int NUM_CLASSES = 7,
    parameter int VEC_W       = 64,
    localparam int CLS_W      = $clog2(NUM_CLASSES),
    localparam int IDX_W      = $clog2(VEC_W)
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         clr_all,
    input logic                         post_valid,
    input logic [CLS_W-1:0]             post_class,
    input logic [IDX_W-1:0]             post_index,
    input logic                         clear_valid,
    input logic [CLS_W-1:0]             clear_class,
    input logic [IDX_W-1:0]             clear_index,
    input logic [NUM_CLASSES-1:0]       summary,
    input logic [NUM_CLASSES*VEC_W-1:0] all_vecs,
    input logic                         bad_class
);
    logic post_ok, clear_ok, any_bad;
    assign post_ok  = post_valid  && (post_class  < CLS_W'(NUM_CLASSES));
    assign clear_ok = clear_valid && (clear_class < CLS_W'(NUM_CLASSES));
    assign any_bad  = (post_valid  && !(post_class  < CLS_W'(NUM_CLASSES))) ||
                      (clear_valid && !(clear_class < CLS_W'(NUM_CLASSES)));

    a_r2_post_sets_bit: assert property (@(posedge clk) disable iff (rst)
        (post_ok && !clr_all) |=>
            (all_vecs[{$past(post_class), $past(post_index)}] && summary[$past(post_class)]));

    // R6: a same-cycle clear never removes the posted bit
    a_r6_post_after_clear: assert property (@(posedge clk) disable iff (rst)
        (post_ok && clear_ok && !clr_all && post_class == clear_class) |=>
            all_vecs[{$past(post_class), $past(post_index)}]);

    a_r3_clear_resets_bit: assert property (@(posedge clk) disable iff (rst)
        (clear_ok && !clr_all &&
         !(post_ok && post_class == clear_class && post_index == clear_index)) |=>
            !all_vecs[{$past(clear_class), $past(clear_index)}]);

    a_r4_clear_all_wipes: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (summary == '0 && all_vecs == '0));

    a_r7_error_raised: assert property (@(posedge clk) disable iff (rst)
        any_bad |=> bad_class);

    a_r7_error_one_cycle: assert property (@(posedge clk) disable iff (rst)
        !any_bad |=> !bad_class);

    a_r7_bad_no_effect: assert property (@(posedge clk) disable iff (rst)
        (any_bad && !post_ok && !clear_ok && !clr_all) |=> $stable(all_vecs));
endmodule

bind irq_pending_store irq_pending_store_chk #(
    .NUM_CLASSES(NUM_CLASSES), .VEC_W(VEC_W)
) u_chk (
    .clk(clk), .rst(rst), .clr_all(clr_all),
    .post_valid(post_valid), .post_class(post_class), .post_index(post_index),
    .clear_valid(clear_valid), .clear_class(clear_class), .clear_index(clear_index),
    .summary(summary), .all_vecs(all_vecs), .bad_class(bad_class)
);

// File: tb/test_irq_pending_store.sv
`timescale 1ns/1ps
module test_irq_pending_store;
    localparam int NC = 7;
    localparam int VW = 64;

    typedef struct {
        string             req;
        logic [NC*VW-1:0]  vecs;
        logic [NC-1:0]     summ;
        logic              err;
    } exp_t;

    logic clk = 1'b0;
    logic rst, clr_all, post_valid, clear_valid;
    logic [2:0] post_class, clear_class, rd_class;
    logic [5:0] post_index, clear_index;
    logic [VW-1:0]    rd_vec;
    logic [NC-1:0]    summary;
    logic [NC*VW-1:0] all_vecs;
    logic             bad_class;

    int checks = 0;
    int errors = 0;
    logic [VW-1:0] mv [NC];
    exp_t q [$];

    always #4 clk = ~clk;

    irq_pending_store i_irq_pending_store (
        .clk(clk), .rst(rst), .clr_all(clr_all),
        .post_valid(post_valid), .post_class(post_class), .post_index(post_index),
        .clear_valid(clear_valid), .clear_class(clear_class), .clear_index(clear_index),
        .rd_class(rd_class), .rd_vec(rd_vec), .summary(summary),
        .all_vecs(all_vecs), .bad_class(bad_class)
    );

    function automatic logic [NC*VW-1:0] pack_model();
        logic [NC*VW-1:0] f;
        for (int c = 0; c < NC; c++) f[c*VW +: VW] = mv[c];
        return f;
    endfunction

    function automatic logic [NC-1:0] summ_model();
        logic [NC-1:0] s;
        for (int c = 0; c < NC; c++) s[c] = |mv[c];
        return s;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [NC*VW-1:0] act, input logic [NC*VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of requests, update model, queue expectation.
    task automatic do_op(input logic pv, input logic [2:0] pc, input logic [5:0] pi,
                         input logic cv, input logic [2:0] cc, input logic [5:0] ci,
                         input logic ca, input string req);
        exp_t e;
        @(negedge clk);
        post_valid = pv; post_class = pc; post_index = pi;
        clear_valid = cv; clear_class = cc; clear_index = ci;
        clr_all = ca;
        if (ca) begin
            for (int c = 0; c < NC; c++) mv[c] = '0;
        end else begin
            if (cv && cc < 3'd7) mv[cc][ci] = 1'b0;
            if (pv && pc < 3'd7) mv[pc][pi] = 1'b1;
        end
        e.req  = req;
        e.vecs = pack_model();
        e.summ = summ_model();
        e.err  = (pv && pc >= 3'd7) || (cv && cc >= 3'd7);
        q.push_back(e);
    endtask

    task automatic idle(input string req);
        do_op(1'b0, 3'd0, 6'd0, 1'b0, 3'd0, 6'd0, 1'b0, req);
    endtask

    task automatic read_check(input logic [2:0] cls, input string req);
        @(negedge clk);
        rd_class = cls;
        #1;
        check(req, "rd_vec", {{(NC-1)*VW{1'b0}}, rd_vec},
              {{(NC-1)*VW{1'b0}}, (cls < 3'd7) ? mv[cls] : {VW{1'b0}}});
    endtask

    // Monitor: compare after each edge that follows a queued request.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.req, "all_vecs", all_vecs, e.vecs);
                check(e.req, "summary", {{(NC*VW-NC){1'b0}}, summary},
                      {{(NC*VW-NC){1'b0}}, e.summ});
                check(e.req, "bad_class", {{(NC*VW-1){1'b0}}, bad_class},
                      {{(NC*VW-1){1'b0}}, e.err});
            end
        end
    end

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; clr_all = 1'b0; post_valid = 1'b0; clear_valid = 1'b0;
        post_class = '0; post_index = '0; clear_class = '0; clear_index = '0;
        rd_class = '0;
        for (int c = 0; c < NC; c++) mv[c] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1", "all_vecs", all_vecs, '0);
        check("R1", "summary", {{(NC*VW-NC){1'b0}}, summary}, '0);
        check("R1", "bad_class", {{(NC*VW-1){1'b0}}, bad_class}, '0);

        // R2 / R8: posts land at class*64+index and raise the summary bit
        do_op(1, 3'd0, 6'd0,  0, 3'd0, 6'd0, 0, "R2");
        do_op(1, 3'd6, 6'd63, 0, 3'd0, 6'd0, 0, "R8");
        do_op(1, 3'd2, 6'd5,  0, 3'd0, 6'd0, 0, "R2");
        do_op(1, 3'd2, 6'd40, 0, 3'd0, 6'd0, 0, "R2");
        idle("R2");
        // R5: combinational read, invalid class reads zero
        read_check(3'd2, "R5");
        read_check(3'd6, "R5");
        read_check(3'd7, "R5");

        // R3: summary holds until the vector is empty
        do_op(0, 3'd0, 6'd0, 1, 3'd2, 6'd5,  0, "R3");
        do_op(0, 3'd0, 6'd0, 1, 3'd2, 6'd40, 0, "R3");

        // R6: same-cycle post and clear in one class
        do_op(1, 3'd3, 6'd7, 1, 3'd3, 6'd7, 0, "R6");
        do_op(1, 3'd3, 6'd1, 1, 3'd3, 6'd7, 0, "R6");

        // R9: redundant post and clear
        do_op(1, 3'd3, 6'd1, 0, 3'd0, 6'd0, 0, "R9");
        do_op(0, 3'd0, 6'd0, 1, 3'd4, 6'd9, 0, "R9");

        // R7: out-of-range class, one-cycle error flag
        do_op(1, 3'd7, 6'd3, 0, 3'd0, 6'd0, 0, "R7");
        idle("R7");
        do_op(1, 3'd5, 6'd2, 1, 3'd7, 6'd2, 0, "R7");
        do_op(0, 3'd0, 6'd0, 1, 3'd7, 6'd1, 0, "R7");
        idle("R7");

        // R4: clear-all beats a same-cycle post
        do_op(1, 3'd1, 6'd3, 1, 3'd0, 6'd0, 1, "R4");
        do_op(1, 3'd4, 6'd20, 0, 3'd0, 6'd0, 0, "R4");
        idle("R4");
        read_check(3'd4, "R5");

        wait (q.size() == 0);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule